// File: doc/BRIEF.md
# Key-Sense Interrupt Merger

This block folds sixteen active-low key-sense lines onto two shared external interrupt channels, a high channel and a low channel. Each channel has its own edge/level detector, its own request flag and its own enable. Key lines 15 to 8 drive the high channel. Key lines 7 to 0 drive the low channel. Each channel also has a dedicated pin. Every key line has a mask bit. A masked line is removed from its channel. The high channel's pin is accepted only while all eight of its key lines are masked. The low channel's pin is accepted only while mask bit 6 is clear.

A mode bit detaches every key line from both channels. In that mode the low channel takes its input from an alternate pin instead of its normal pin, and the high channel keeps its own pin. Software sets the mask, the mode, the sense fields and the enables through a small write port. The same port clears request flags with write-one-to-clear. Each interrupt output is the channel's request flag gated by that channel's enable.

Top module: `keysense_irq_merge`

## Requirements
- R1: After reset both interrupt outputs are 0, every mask bit is 1 (all keys masked), mode is 0, both enables are 0 and both flags are clear.
- R2: In mode 0 an active (low) unmasked key line in 15..8 raises only the high channel, and one in 7..0 raises only the low channel.
- R3: Mask register bit k at 1 removes key line k from its channel. A masked line never raises a request.
- R4: In mode 0 the high channel's dedicated pin counts only when mask bits 15..8 are all 1. Otherwise the pin is ignored.
- R5: In mode 0 the low channel's normal pin counts only when mask bit 6 is 0.
- R6: In mode 1 all key lines are ignored. The low channel follows the alternate pin and the high channel follows its own pin.
- R7: The sense field selects the detection: 00 low level, 01 falling edge, 10 rising edge, 11 either edge. A channel's input is active low, and it is the AND of its pin and its unmasked keys.
- R8: A detected event sets the channel's flag. The flag holds until cleared by writing 1 to bit 0 (low) or bit 1 (high) at address 2. The output is flag AND enable. Disabling the channel hides the request but keeps the flag.
- R9: In low-level mode a clear is overridden while the input stays low, so the flag stays set.
- R10: In an edge mode, a clear that lands in the same cycle as a new edge leaves the flag set.
- R11: An input change reaches the output on the third rising clock edge: two synchronizer stages and then the flag.
- R12: Write port layout: address 0 is the 16-bit mask. Address 1 holds mode (bit 0), low sense (bits 2:1), low enable (bit 3), high sense (bits 5:4) and high enable (bit 6). Address 2 is the flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_n | input | 16 | Raw key-sense lines, active low |
| pin_hi_n | input | 1 | Dedicated pin of the high channel |
| pin_lo_n | input | 1 | Normal pin of the low channel |
| pin_lo_alt_n | input | 1 | Alternate pin of the low channel (mode 1) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 16 | Register write data |
| irq_hi | output | 1 | High channel interrupt request |
| irq_lo | output | 1 | Low channel interrupt request |

## Verification
A flag-clear write and a fresh detection on the same channel can fall in the same cycle. The bench provokes this on purpose. It drives an edge on a pin, waits two edges, and places the clear strobe so it lands on the edge where the detection reaches the flag. The flag must then survive. The bench also clears while the input is held low in level mode, where the flag must also survive. Random traffic then mixes clear writes with key, pin, mask and mode changes, and a cycle-level reference model built from the requirements judges every cycle.

// File: rtl/keysense_irq_merge.sv
module keysense_irq_merge #(
  parameter int KEYS       = 16,
  parameter int LO_PIN_BIT = 6,
  parameter int AW         = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [KEYS-1:0] key_n,
  input  logic            pin_hi_n,
  input  logic            pin_lo_n,
  input  logic            pin_lo_alt_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [KEYS-1:0] wr_data,
  output logic            irq_hi,
  output logic            irq_lo
);
  localparam int HALF = KEYS / 2;
  localparam int SW   = KEYS + 3;

  logic [SW-1:0]   s1, s2;
  logic [KEYS-1:0] mask, key_s, keys_eff;
  logic            mode, en_lo, en_hi;
  logic [1:0]      sense_lo, sense_hi;
  logic            prev_lo, prev_hi, flag_lo, flag_hi;
  logic            comb_lo, comb_hi, hit_lo, hit_hi, clr_lo, clr_hi;
  logic            phi_s, plo_s, palt_s, hi_pin_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '1;
      s2 <= '1;
    end else begin
      s1 <= {pin_lo_alt_n, pin_lo_n, pin_hi_n, key_n};
      s2 <= s1;
    end

  assign key_s  = s2[KEYS-1:0];
  assign phi_s  = s2[KEYS];
  assign plo_s  = s2[KEYS+1];
  assign palt_s = s2[KEYS+2];

  assign keys_eff  = key_s | mask;
  assign hi_pin_ok = &mask[KEYS-1:HALF];

  assign comb_hi = mode ? phi_s
                        : (&keys_eff[KEYS-1:HALF]) & (phi_s | ~hi_pin_ok);
  assign comb_lo = mode ? palt_s
                        : (&keys_eff[HALF-1:0]) & (plo_s | mask[LO_PIN_BIT]);

  function automatic logic detect(input logic [1:0] sel, input logic cur, input logic old);
    case (sel)
      2'b00:   return ~cur;
      2'b01:   return old & ~cur;
      2'b10:   return ~old & cur;
      default: return old ^ cur;
    endcase
  endfunction

  assign hit_lo = detect(sense_lo, comb_lo, prev_lo);
  assign hit_hi = detect(sense_hi, comb_hi, prev_hi);

  assign clr_lo = wr_en && wr_addr == AW'(2) && wr_data[0];
  assign clr_hi = wr_en && wr_addr == AW'(2) && wr_data[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mask     <= '1;
      mode     <= 1'b0;
      sense_lo <= 2'b00;
      sense_hi <= 2'b00;
      en_lo    <= 1'b0;
      en_hi    <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == AW'(0)) mask <= wr_data;
      if (wr_addr == AW'(1)) begin
        mode     <= wr_data[0];
        sense_lo <= wr_data[2:1];
        en_lo    <= wr_data[3];
        sense_hi <= wr_data[5:4];
        en_hi    <= wr_data[6];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev_lo <= 1'b1;
      prev_hi <= 1'b1;
      flag_lo <= 1'b0;
      flag_hi <= 1'b0;
    end else begin
      prev_lo <= comb_lo;
      prev_hi <= comb_hi;
      flag_lo <= hit_lo | (flag_lo & ~clr_lo);
      flag_hi <= hit_hi | (flag_hi & ~clr_hi);
    end

  assign irq_lo = flag_lo & en_lo;
  assign irq_hi = flag_hi & en_hi;
endmodule

// File: rtl/keysense_irq_merge_chk.sv
module keysense_irq_merge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] sense_lo,
  input logic [1:0] sense_hi,
  input logic       comb_lo,
  input logic       comb_hi,
  input logic       prev_lo,
  input logic       prev_hi,
  input logic       flag_lo,
  input logic       flag_hi,
  input logic       clr_lo,
  input logic       clr_hi
);
  p_level_hold_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_lo == 2'b00 && !comb_lo) |=> flag_lo);
  p_level_hold_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_hi == 2'b00 && !comb_hi) |=> flag_hi);
  p_edge_needs_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_lo != 2'b00 && comb_lo == prev_lo && !flag_lo) |=> !flag_lo);
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_hi && !clr_hi) |=> flag_hi);
  p_clear_takes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_lo && sense_lo != 2'b00 && comb_lo == prev_lo) |=> !flag_lo);
  p_prev_tracks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (prev_hi == $past(comb_hi)));
endmodule

bind keysense_irq_merge keysense_irq_merge_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .sense_lo(sense_lo), .sense_hi(sense_hi),
  .comb_lo(comb_lo), .comb_hi(comb_hi),
  .prev_lo(prev_lo), .prev_hi(prev_hi),
  .flag_lo(flag_lo), .flag_hi(flag_hi),
  .clr_lo(clr_lo), .clr_hi(clr_hi)
);

// File: tb/keysense_irq_merge_bench.sv
module keysense_irq_merge_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] key_n = '1;
  logic        pin_hi_n = 1'b1, pin_lo_n = 1'b1, pin_lo_alt_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        irq_hi, irq_lo;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keysense_irq_merge u_keysense_irq_merge (
    .clk(clk), .rst_n(rst_n), .key_n(key_n), .pin_hi_n(pin_hi_n),
    .pin_lo_n(pin_lo_n), .pin_lo_alt_n(pin_lo_alt_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .irq_hi(irq_hi), .irq_lo(irq_lo));

  // reference model, built from R2..R12
  logic [18:0] m_s1, m_s2;
  logic [15:0] m_mask;
  logic [6:0]  m_ctrl;
  logic m_plo, m_phi, m_flo, m_fhi;

  function automatic logic m_hit(input logic [1:0] sel, input logic cur, input logic old);
    if (sel == 2'b00) return !cur;
    if (sel == 2'b01) return old && !cur;
    if (sel == 2'b10) return !old && cur;
    return old != cur;
  endfunction

  function automatic logic m_in_hi(input logic [18:0] s, input logic [15:0] mk, input logic md);
    logic keys_ok = 1'b1;
    for (int k = 8; k < 16; k++) if (!mk[k] && !s[k]) keys_ok = 1'b0;
    if (md) return s[16];
    if (mk[15:8] == 8'hFF) return keys_ok && s[16];
    return keys_ok;
  endfunction

  function automatic logic m_in_lo(input logic [18:0] s, input logic [15:0] mk, input logic md);
    logic keys_ok = 1'b1;
    for (int k = 0; k < 8; k++) if (!mk[k] && !s[k]) keys_ok = 1'b0;
    if (md) return s[18];
    if (!mk[6]) return keys_ok && s[17];
    return keys_ok;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '1; m_s2 <= '1; m_mask <= '1; m_ctrl <= '0;
      m_plo <= 1'b1; m_phi <= 1'b1; m_flo <= 1'b0; m_fhi <= 1'b0;
    end else begin
      logic cl, ch, clrl, clrh;
      cl = m_in_lo(m_s2, m_mask, m_ctrl[0]);
      ch = m_in_hi(m_s2, m_mask, m_ctrl[0]);
      clrl = wr_en && wr_addr == 2'd2 && wr_data[0];
      clrh = wr_en && wr_addr == 2'd2 && wr_data[1];
      m_s1 <= {pin_lo_alt_n, pin_lo_n, pin_hi_n, key_n};
      m_s2 <= m_s1;
      m_plo <= cl; m_phi <= ch;
      m_flo <= m_hit(m_ctrl[2:1], cl, m_plo) || (m_flo && !clrl);
      m_fhi <= m_hit(m_ctrl[5:4], ch, m_phi) || (m_fhi && !clrh);
      if (wr_en && wr_addr == 2'd0) m_mask <= wr_data;
      if (wr_en && wr_addr == 2'd1) m_ctrl <= wr_data[6:0];
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    if (!done) $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    check("R1 irq_hi after reset", irq_hi, 1'b0);
    check("R1 irq_lo after reset", irq_lo, 1'b0);
    rst_n = 1'b1;
    tick(2);
    pin_hi_n = 1'b0; tick(4);
    check("R1 disabled after reset", irq_hi, 1'b0);
    pin_hi_n = 1'b1; tick(3);

    // R12 layout, low pin, level mode, latency
    wr(2'd2, 16'h3);
    wr(2'd0, 16'hFFBF);
    wr(2'd1, 16'h0008);
    pin_lo_n = 1'b0; tick(2);
    check("R11 not yet after two edges", irq_lo, 1'b0);
    tick(1);
    check("R11 R5 seen on third edge", irq_lo, 1'b1);
    wr(2'd2, 16'h1);
    check("R9 level clear overridden", irq_lo, 1'b1);
    pin_lo_n = 1'b1; tick(3);
    wr(2'd2, 16'h1);
    check("R8 clear takes", irq_lo, 1'b0);
    wr(2'd0, 16'hFFFF);
    pin_lo_n = 1'b0; tick(4);
    check("R5 low pin ignored with mask6=1", irq_lo, 1'b0);
    pin_lo_n = 1'b1; tick(3);

    // R4 high pin
    wr(2'd1, 16'h0040);
    pin_hi_n = 1'b0; tick(3);
    check("R4 high pin honoured", irq_hi, 1'b1);
    pin_hi_n = 1'b1; tick(3);
    wr(2'd2, 16'h2);
    wr(2'd0, 16'h7FFF);
    pin_hi_n = 1'b0; tick(4);
    check("R4 high pin ignored", irq_hi, 1'b0);
    pin_hi_n = 1'b1; tick(3);

    // R2 / R3 key mapping and masking
    wr(2'd1, 16'h0048);
    wr(2'd0, 16'hFEFF);
    key_n[8] = 1'b0; tick(3);
    check("R2 key8 to high", irq_hi, 1'b1);
    check("R2 key8 not low", irq_lo, 1'b0);
    key_n[8] = 1'b1; tick(3);
    wr(2'd2, 16'h3);
    key_n[9] = 1'b0; tick(4);
    check("R3 masked key9", irq_hi, 1'b0);
    key_n[9] = 1'b1;
    wr(2'd0, 16'hFFFE);
    key_n[0] = 1'b0; tick(3);
    check("R2 key0 to low", irq_lo, 1'b1);
    check("R2 key0 not high", irq_hi, 1'b0);
    key_n[0] = 1'b1; tick(3);
    wr(2'd2, 16'h3);

    // R6 mode 1
    wr(2'd1, 16'h0049);
    wr(2'd0, 16'h0000);
    key_n = '0; tick(4);
    check("R6 keys ignored high", irq_hi, 1'b0);
    check("R6 keys ignored low", irq_lo, 1'b0);
    key_n = '1;
    pin_lo_alt_n = 1'b0; tick(3);
    check("R6 alternate pin", irq_lo, 1'b1);
    pin_lo_alt_n = 1'b1; tick(3);
    wr(2'd2, 16'h3);

    // R7 sense modes on low pin
    wr(2'd0, 16'hFFBF);
    wr(2'd1, 16'h000A);
    pin_lo_n = 1'b0; tick(3);
    check("R7 falling detected", irq_lo, 1'b1);
    wr(2'd2, 16'h1);
    check("R7 falling not level", irq_lo, 1'b0);
    pin_lo_n = 1'b1; tick(4);
    check("R7 rise ignored in falling", irq_lo, 1'b0);
    wr(2'd1, 16'h000C);
    pin_lo_n = 1'b0; tick(4);
    check("R7 fall ignored in rising", irq_lo, 1'b0);
    pin_lo_n = 1'b1; tick(3);
    check("R7 rising detected", irq_lo, 1'b1);
    wr(2'd2, 16'h1);
    wr(2'd1, 16'h000E);
    pin_lo_n = 1'b0; tick(3);
    check("R7 both: fall", irq_lo, 1'b1);
    wr(2'd2, 16'h1);
    pin_lo_n = 1'b1; tick(3);
    check("R7 both: rise", irq_lo, 1'b1);
    wr(2'd2, 16'h1);

    // R10 clear colliding with edge
    wr(2'd1, 16'h000A);
    pin_lo_n = 1'b0; tick(2);
    wr(2'd2, 16'h1);
    check("R10 edge beats clear", irq_lo, 1'b1);
    wr(2'd1, 16'h0002);
    check("R8 disabled hides", irq_lo, 1'b0);
    wr(2'd1, 16'h000A);
    check("R8 flag kept while disabled", irq_lo, 1'b1);
    pin_lo_n = 1'b1; tick(3);

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 20) key_n[$urandom_range(0, 15)] ^= 1'b1;
      else if (r < 26) pin_hi_n = ~pin_hi_n;
      else if (r < 32) pin_lo_n = ~pin_lo_n;
      else if (r < 36) pin_lo_alt_n = ~pin_lo_alt_n;
      if ($urandom_range(0, 99) < 8) begin
        wr_en = 1'b1;
        wr_addr = 2'($urandom_range(0, 2));
        wr_data = 16'($urandom());
        if (wr_addr == 2'd1) wr_data[0] = ($urandom_range(0, 4) == 0);
      end else wr_en = 1'b0;
      @(posedge clk); @(negedge clk);
      check("R2 R3 R4 R5 R6 R7 R8 model high", irq_hi, m_fhi && m_ctrl[6]);
      check("R2 R3 R5 R6 R7 R8 model low", irq_lo, m_flo && m_ctrl[3]);
    end
    wr_en = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule